// File: doc/BRIEF.md
# GPIO Interrupt Slot Selector

This block maps a wide bus of GPIO interrupt lines onto a fixed set of interrupt slots. Each slot picks one line from the bus and gates it with an enable. It detects events on that line using a per-slot sense mode: rising edge, falling edge, level high or level low. A detected event latches a sticky per-slot status bit, and the slot then drives an active-high level request towards a parent interrupt controller.

Software configures the block through a word-addressed register port. Each slot owns one source byte, a 2-bit sense field and a bit in the shared status word. The expected way to retarget a slot has four steps:

1. Write its byte with the new source and the enable clear.
2. Set the sense field.
3. Clear its status bit.
4. Set the enable.

Edge history is reloaded whenever a slot's source index changes, so a retargeted slot never reports a false edge from the old line.

Top module: `gpio_slot_irq_sel`

## Requirements
- R1: After reset every register reads 0 and all `irq_o` bits are 0.
- R2: Word addresses 0 to 7 are source registers. Slot n's byte is register n/4, bits [8*(n%4)+7 : 8*(n%4)]. Bit 7 of the byte is the enable and bits [6:0] index the `gpio_irq_i` bus. Written values read back unchanged.
- R3: Word addresses 8 and 9 are sense registers. Slot n's 2-bit field is register 8+n/16 at bit offset 2*(n%16). The codes are 0 rising edge, 1 falling edge, 2 level high and 3 level low. Written values read back unchanged.
- R4: In rising mode, a 0-to-1 change on the selected line sets the slot's status. A steady high line and a 1-to-0 change do not set it.
- R5: In falling mode, a 1-to-0 change on the selected line sets status. A 0-to-1 change does not set it.
- R6: In level-high mode, status is set in every cycle the line is high, so clearing it while the line stays high has no lasting effect.
- R7: In level-low mode, status is set in every cycle the line is low.
- R8: Word address 10 is the status register, with bit n belonging to slot n. Writing 0 to a bit clears it. Writing 1 leaves it unchanged. A set bit stays set until cleared.
- R9: `irq_o[n]` is status bit n gated by slot n's enable. It rises one clock edge after the edge on which the event is present at the inputs.
- R10: While a slot's enable is 0, no event latches status for it, and its request stays low.
- R11: Changing a slot's source index does not by itself produce an edge event, even if the old and new lines differ in level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_irq_i | input | SRC_W | GPIO interrupt lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i`, combinational |
| irq_o | output | NUM_SLOTS | Per-slot active-high request |

## Verification
Register writes take effect on the clock edge that samples the strobe. A line change driven before an edge is latched into status on that edge, so `irq_o` and the status readback are due one edge later. Level-low events appear one edge after the enable write lands. After a source-index change, the first edge is the history-reload edge and reports nothing. The bench drives inputs on falling edges, crosses exactly the expected number of rising edges, and samples at the next falling edge. It also samples once before the edge to confirm the request is not early. Read data is combinational and is sampled shortly after the address is set, away from any edge.

// File: rtl/gsel_pkg.sv
package gsel_pkg;
  localparam int SENSE_W = 2;
  localparam int SLOT_BYTE_W = 8;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;
endpackage

// File: rtl/gsel_cfg.sv
module gsel_cfg
  import gsel_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [SLOT_BYTE_W-1:0] slot_byte_o  [NUM_SLOTS],
  output logic [SENSE_W-1:0]     slot_sense_o [NUM_SLOTS]
);
  localparam int SLOTS_PER_SRC   = DATA_W / SLOT_BYTE_W;
  localparam int SLOTS_PER_SENSE = DATA_W / SENSE_W;
  localparam int N_SRC           = NUM_SLOTS / SLOTS_PER_SRC;
  localparam int N_SENSE         = NUM_SLOTS / SLOTS_PER_SENSE;

  logic [DATA_W-1:0] src_q   [N_SRC];
  logic [DATA_W-1:0] sense_q [N_SENSE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SRC; i++) src_q[i] <= '0;
      for (int i = 0; i < N_SENSE; i++) sense_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N_SRC; i++)
        if (addr_i == ADDR_W'(i)) src_q[i] <= wdata_i;
      for (int i = 0; i < N_SENSE; i++)
        if (addr_i == ADDR_W'(N_SRC + i)) sense_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = src_q[i];
    for (int i = 0; i < N_SENSE; i++)
      if (addr_i == ADDR_W'(N_SRC + i)) rdata_o = sense_q[i];
  end

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot_map
    assign slot_byte_o[n] =
      src_q[n / SLOTS_PER_SRC][SLOT_BYTE_W*(n % SLOTS_PER_SRC) +: SLOT_BYTE_W];
    assign slot_sense_o[n] =
      sense_q[n / SLOTS_PER_SENSE][SENSE_W*(n % SLOTS_PER_SENSE) +: SENSE_W];
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src_chk
    // R2: source registers change only on a write
    a_r2_src_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(src_q[i]))
      else $error("source register %0d changed without write", i);
  end

  for (genvar i = 0; i < N_SENSE; i++) begin : g_sense_chk
    // R3: sense registers change only on a write
    a_r3_sense_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(sense_q[i]))
      else $error("sense register %0d changed without write", i);
  end
endmodule

// File: rtl/gsel_slot.sv
module gsel_slot
  import gsel_pkg::*;
#(
  parameter int SRC_W = 128,
  parameter int IDX_W = $clog2(SRC_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   src_i,
  input  logic               en_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [SENSE_W-1:0] sense_i,
  output logic               evt_o
);
  logic             sel;
  logic             prev_q;
  logic [IDX_W-1:0] idx_q;
  logic             swap;
  logic             hit;

  assign sel  = src_i[idx_i];
  // history belongs to a different line for one cycle after a retarget
  assign swap = (idx_i != idx_q);

  always_comb begin
    unique case (sense_e'(sense_i))
      SENSE_RISE: hit =  sel & ~prev_q & ~swap;
      SENSE_FALL: hit = ~sel &  prev_q & ~swap;
      SENSE_HIGH: hit =  sel;
      SENSE_LOW:  hit = ~sel;
      default:    hit = 1'b0;
    endcase
  end

  assign evt_o = en_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      prev_q <= sel;
      idx_q  <= idx_i;
    end
  end
endmodule

// File: rtl/gpio_slot_irq_sel.sv
module gpio_slot_irq_sel
  import gsel_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SRC_W     = 128,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(SRC_W),
  localparam int N_SRC    = NUM_SLOTS * SLOT_BYTE_W / DATA_W,
  localparam int N_SENSE  = NUM_SLOTS * SENSE_W / DATA_W,
  localparam int STAT_ADR = N_SRC + N_SENSE,
  localparam int ADDR_W   = $clog2(STAT_ADR + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SRC_W-1:0]     gpio_irq_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [NUM_SLOTS-1:0] irq_o
);
  logic [SLOT_BYTE_W-1:0] slot_byte  [NUM_SLOTS];
  logic [SENSE_W-1:0]     slot_sense [NUM_SLOTS];
  logic [DATA_W-1:0]      cfg_rdata;
  logic [NUM_SLOTS-1:0]   evt;
  logic [NUM_SLOTS-1:0]   slot_en;
  logic [NUM_SLOTS-1:0]   status_q;
  logic [NUM_SLOTS-1:0]   status_d;
  logic                   stat_wr;

  gsel_cfg #(
    .NUM_SLOTS(NUM_SLOTS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (cfg_rdata),
    .slot_byte_o (slot_byte),
    .slot_sense_o(slot_sense)
  );

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    assign slot_en[n] = slot_byte[n][SLOT_BYTE_W-1];

    gsel_slot #(
      .SRC_W(SRC_W),
      .IDX_W(IDX_W)
    ) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (gpio_irq_i),
      .en_i   (slot_en[n]),
      .idx_i  (slot_byte[n][IDX_W-1:0]),
      .sense_i(slot_sense[n]),
      .evt_o  (evt[n])
    );
  end

  assign stat_wr = reg_we_i && (reg_addr_i == ADDR_W'(STAT_ADR));

  // a new event wins over a same-cycle clear
  assign status_d = (stat_wr ? (status_q & reg_wdata_i[NUM_SLOTS-1:0]) : status_q) | evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign irq_o       = status_q & slot_en;
  assign reg_rdata_o = (reg_addr_i == ADDR_W'(STAT_ADR)) ? DATA_W'(status_q) : cfg_rdata;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_chk
    a_r10_no_latch_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!slot_en[n] && !status_q[n]) |=> !status_q[n])
      else $error("disabled slot %0d latched status", n);

    a_r8_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_wr && !reg_wdata_i[n] && !evt[n]) |=> !status_q[n])
      else $error("status %0d not cleared", n);

    a_r8_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q[n] && !(stat_wr && !reg_wdata_i[n])) |=> status_q[n])
      else $error("status %0d dropped without clear", n);
  end
endmodule

// File: tb/gpio_slot_irq_sel_bench.sv
module gpio_slot_irq_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SLOTS  = 32;
  localparam int SRC_W      = 128;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int SENSE_ADR  = 8;
  localparam int STAT_ADR   = 10;
  localparam int WD_LIMIT   = 20000;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [SRC_W-1:0]     gpio_irq_i = '0;
  logic                 reg_we_i = 1'b0;
  logic [ADDR_W-1:0]    reg_addr_i = '0;
  logic [DATA_W-1:0]    reg_wdata_i = '0;
  logic [DATA_W-1:0]    reg_rdata_o;
  logic [NUM_SLOTS-1:0] irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] src_sh   [8];
  logic [31:0] sense_sh [2];

  gpio_slot_irq_sel u_gpio_slot_irq_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gpio_irq_i (gpio_irq_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input int adr, input logic [31:0] d);
    reg_we_i    = 1'b1;
    reg_addr_i  = ADDR_W'(adr);
    reg_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int adr, output logic [31:0] d);
    reg_addr_i = ADDR_W'(adr);
    #1;
    d = reg_rdata_o;
  endtask

  task automatic clr_stat(input int n);
    wr(STAT_ADR, ~(32'h1 << n));
  endtask

  task automatic set_byte(input int n, input logic [7:0] b);
    src_sh[n/4][8*(n%4) +: 8] = b;
    wr(n/4, src_sh[n/4]);
  endtask

  // retarget order: byte with enable off, sense, clear status, enable
  task automatic cfg_slot(input int n, input int idx, input logic [1:0] sense);
    set_byte(n, {1'b0, 7'(idx)});
    sense_sh[n/16][2*(n%16) +: 2] = sense;
    wr(SENSE_ADR + n/16, sense_sh[n/16]);
    clr_stat(n);
    set_byte(n, {1'b1, 7'(idx)});
  endtask

  task automatic off_slot(input int n);
    set_byte(n, 8'h00);
    clr_stat(n);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a <= STAT_ADR; a++) begin
      rd(a, d);
      chk("R1 reset register", d, 32'h0);
    end
    chk("R1 reset irq", irq_o, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(2, 32'h7F1E_2A05);
    rd(2, d);
    chk("R2 source readback", d, 32'h7F1E_2A05);
    wr(SENSE_ADR + 1, 32'hA5A5_0F0F);
    rd(SENSE_ADR + 1, d);
    chk("R3 sense readback", d, 32'hA5A5_0F0F);
    wr(2, 32'h0);
    wr(SENSE_ADR + 1, 32'h0);
    rd(2, d);
    chk("R2 source cleared", d, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    cfg_slot(5, 17, 2'd0);
    gpio_irq_i[17] = 1'b1;
    #1;
    chk("R9 no early request", irq_o, 32'h0);
    step();
    chk("R4 R9 rising sets request", irq_o, 32'h1 << 5);
    rd(STAT_ADR, d);
    chk("R4 rising status", d, 32'h1 << 5);
    clr_stat(5);
    step();
    chk("R4 steady high no event", irq_o, 32'h0);
    gpio_irq_i[17] = 1'b0;
    step();
    chk("R4 falling ignored in rise mode", irq_o, 32'h0);
    off_slot(5);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    gpio_irq_i[100] = 1'b1;
    cfg_slot(18, 100, 2'd1);
    step();
    chk("R5 high steady no event", irq_o, 32'h0);
    gpio_irq_i[100] = 1'b0;
    step();
    chk("R5 falling sets request", irq_o, 32'h1 << 18);
    clr_stat(18);
    gpio_irq_i[100] = 1'b1;
    step();
    rd(STAT_ADR, d);
    chk("R5 rising ignored in fall mode", d, 32'h0);
    gpio_irq_i[100] = 1'b0;
    off_slot(18);
  endtask

  task automatic t_level_high();
    logic [31:0] d;
    cfg_slot(31, 127, 2'd2);
    step();
    chk("R6 low line no event", irq_o, 32'h0);
    gpio_irq_i[127] = 1'b1;
    step();
    chk("R6 level high request", irq_o, 32'h8000_0000);
    clr_stat(31);
    step();
    rd(STAT_ADR, d);
    chk("R6 clear while high re-sets", d, 32'h8000_0000);
    gpio_irq_i[127] = 1'b0;
    step();
    clr_stat(31);
    step();
    rd(STAT_ADR, d);
    chk("R6 clear after drop", d, 32'h0);
    off_slot(31);
  endtask

  task automatic t_level_low();
    logic [31:0] d;
    cfg_slot(0, 3, 2'd3);
    step();
    chk("R7 level low request", irq_o, 32'h1);
    gpio_irq_i[3] = 1'b1;
    step();
    clr_stat(0);
    step();
    rd(STAT_ADR, d);
    chk("R7 high line no event", d, 32'h0);
    gpio_irq_i[3] = 1'b0;
    off_slot(0);
  endtask

  task automatic t_clear_sel();
    logic [31:0] d;
    cfg_slot(5, 20, 2'd0);
    cfg_slot(6, 21, 2'd0);
    gpio_irq_i[20] = 1'b1;
    gpio_irq_i[21] = 1'b1;
    step();
    rd(STAT_ADR, d);
    chk("R8 both latched", d, 32'h60);
    clr_stat(5);
    rd(STAT_ADR, d);
    chk("R8 selective clear", d, 32'h40);
    step();
    step();
    rd(STAT_ADR, d);
    chk("R8 status sticky", d, 32'h40);
    gpio_irq_i[20] = 1'b0;
    gpio_irq_i[21] = 1'b0;
    off_slot(5);
    off_slot(6);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    set_byte(7, 8'd40);
    gpio_irq_i[40] = 1'b1;
    step();
    gpio_irq_i[40] = 1'b0;
    step();
    rd(STAT_ADR, d);
    chk("R10 disabled no status", d, 32'h0);
    chk("R10 disabled no request", irq_o, 32'h0);
    set_byte(7, 8'h80 | 8'd40);
    step();
    chk("R10 enable after pulse no request", irq_o, 32'h0);
    off_slot(7);
  endtask

  task automatic t_swap();
    logic [31:0] d;
    gpio_irq_i[51] = 1'b1;
    cfg_slot(9, 50, 2'd0);
    set_byte(9, 8'h80 | 8'd51);
    step();
    step();
    rd(STAT_ADR, d);
    chk("R11 retarget no false edge", d, 32'h0);
    gpio_irq_i[51] = 1'b0;
    step();
    gpio_irq_i[51] = 1'b1;
    step();
    chk("R11 new line edge detected", irq_o, 32'h1 << 9);
    gpio_irq_i[51] = 1'b0;
    off_slot(9);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) src_sh[i] = '0;
    for (int i = 0; i < 2; i++) sense_sh[i] = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_layout();
    t_rise();
    t_fall();
    t_level_high();
    t_level_low();
    t_clear_sel();
    t_disabled();
    t_swap();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule